// File: doc/BRIEF.md
# Sprite/Background Character Bank Set Selector

This block decides, on every character-memory fetch of a tile-based video controller, whether the sprite bank set (set A) or the background bank set (set B) should supply the character-memory bank. The bank registers and the address multiplexing live elsewhere. This block only produces the one-bit select.

It works out the sprite size by watching CPU writes to the two video-controller configuration registers. It finds the start of each scanline by watching video-memory read addresses. Within a scanline it numbers the fetches with a counter that stops at its maximum instead of wrapping. During rendering the select follows a fixed fetch window. When no rendering is going on, the select follows whichever bank set the CPU wrote last.

Every input is sampled on the block clock `clk`. A video-memory fetch is one falling edge of `ppu_rd_n`. The select that applies to a fetch is valid from the first clock edge that sees that falling edge until the next fetch arrives.

Top module: `chr_set_selector`

## Requirements
- R1: After reset the block is in tall-sprite (8x16) mode, outside a frame, with set A as the last-written set, so `bg_set_sel` is 0. A later write to the set-B range then drives it to 1 without any configuration write.
- R2: Tall-sprite mode is on only when the last write to $2000 had bit 5 set and the last write to $2001 had bit 3 or bit 4 set. Otherwise `bg_set_sel` is 0 (set A) at all times.
- R3: Only the exact CPU addresses $2000 and $2001 are decoded. Writes to their mirrors ($2008-$3FFF in steps of 8, and one above each) have no effect on the select.
- R4: Outside a frame in tall-sprite mode, `bg_set_sel` is 0 after a write to $5120-$5127 and 1 after a write to $5128-$512B. Writes to any other address in $5110-$513F leave it unchanged.
- R5: A write to $2000 with bit 5 clear makes set A the last-written set. Writes to $5128-$512B are ignored while bit 5 of $2000 is clear.
- R6: A scanline starts on the third consecutive fetch whose address has bits 13:12 = 2'b10, and that fetch is fetch #1. The first scanline after idle enters the frame. Fetches before it, such as the pre-render line, use the out-of-frame rule even inside the fetch window.
- R7: In a frame in tall-sprite mode, fetches #130 to #161 of every scanline give 0 (set A), and all other fetches give 1 (set B).
- R8: On the first scanline of a frame only, fetches #2 to #4 also give 0.
- R9: The fetch number stops at 170. Further fetches in the same scanline stay at 170 and give 1.
- R10: The number of scanlines in a frame is not limited. The fetch window still applies on scanline 299.
- R11: Once 32 clock cycles pass with no fetch, the frame ends and the out-of-frame rule applies again. One cycle earlier the block is still in the frame.
- R12: A fetch is counted once, on the falling edge of `ppu_rd_n`, however long the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU bus address |
| cpu_data | input | 8 | CPU bus write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 14 | Video-memory fetch address |
| ppu_rd_n | input | 1 | Video-memory read strobe, active low |
| bg_set_sel | output | 1 | 0 selects the sprite set A, 1 selects the background set B |

## Verification
The hardest state to reach from the ports is a fetch number above 161 that has to stay there, together with a strobe held low that must not advance the count. Both sit deep inside a scanline, which the bench can only reach by replaying whole lines of fetch addresses. The bench builds a 340-fetch scanline where a wrapping counter would fall back into the set-A window, and it holds one fetch low for four cycles just before the window opens. It also sweeps every control byte, every register mirror and the whole bank-register neighbourhood, and it runs a 300-line frame so that the window is still checked on lines far past a normal frame height.

// File: rtl/chrsel_pkg.sv
package chrsel_pkg;

  // Which character bank set drives the bank outputs.
  typedef enum logic {
    SET_SPR = 1'b0,   // set A, the sprite set
    SET_BG  = 1'b1    // set B, the background set
  } bank_set_e;

endpackage

// File: rtl/chrsel_cpu_snoop.sv
module chrsel_cpu_snoop
  import chrsel_pkg::*;
#(
  parameter int CPU_AW = 16,
  parameter int CPU_DW = 8,
  parameter logic [CPU_AW-1:0] CTRL_ADDR = 16'h2000,
  parameter logic [CPU_AW-1:0] MASK_ADDR = 16'h2001,
  parameter int TALL_BIT = 5,
  parameter int SHOW_LO_BIT = 3,
  parameter int SHOW_HI_BIT = 4,
  parameter logic [CPU_AW-1:0] SPR_BASE = 16'h5120,
  parameter int SPR_COUNT = 8,
  parameter logic [CPU_AW-1:0] BG_BASE = 16'h5128,
  parameter int BG_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [CPU_DW-1:0] cpu_data,
  input  logic              cpu_wr,
  output logic              tall_mode,
  output bank_set_e         last_set
);

  localparam logic [CPU_AW-1:0] SPR_END = SPR_BASE + CPU_AW'(SPR_COUNT);
  localparam logic [CPU_AW-1:0] BG_END  = BG_BASE + CPU_AW'(BG_COUNT);

  logic      tall_q, tall_d;
  logic      show_q, show_d;
  bank_set_e last_q, last_d;
  logic      spr_hit, bg_hit;

  assign spr_hit = (cpu_addr >= SPR_BASE) && (cpu_addr < SPR_END);
  assign bg_hit  = (cpu_addr >= BG_BASE) && (cpu_addr < BG_END);

  // Next state for one CPU write; the register process enables on cpu_wr.
  always_comb begin
    tall_d = tall_q;
    show_d = show_q;
    last_d = last_q;
    if (cpu_addr == CTRL_ADDR) begin
      tall_d = cpu_data[TALL_BIT];
      if (!cpu_data[TALL_BIT]) begin
        last_d = SET_SPR;
      end
    end
    if (cpu_addr == MASK_ADDR) begin
      show_d = cpu_data[SHOW_LO_BIT] | cpu_data[SHOW_HI_BIT];
    end
    if (spr_hit) begin
      last_d = SET_SPR;
    end
    if (bg_hit && tall_q) begin
      last_d = SET_BG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tall_q <= 1'b1;
      show_q <= 1'b1;
      last_q <= SET_SPR;
    end else if (cpu_wr) begin
      tall_q <= tall_d;
      show_q <= show_d;
      last_q <= last_d;
    end
  end

  assign tall_mode = tall_q & show_q;
  assign last_set  = last_q;

endmodule

// File: rtl/chrsel_line_track.sv
module chrsel_line_track #(
  parameter int PPU_AW = 14,
  parameter int FETCH_MAX = 170,
  parameter int NT_RUN = 3,
  parameter int IDLE_LIMIT = 32,
  parameter logic [1:0] NT_TAG = 2'b10,
  localparam int CNT_W = $clog2(FETCH_MAX + 1),
  localparam int RUN_W = $clog2(NT_RUN + 1),
  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic              ppu_rd_n,
  output logic              rd_fall,
  output logic              idle_hit,
  output logic [CNT_W-1:0]  fetch_cnt,
  output logic              in_frame,
  output logic              first_line
);

  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(FETCH_MAX);
  localparam logic [RUN_W-1:0]  RUN_MAX  = RUN_W'(NT_RUN);
  localparam logic [RUN_W-1:0]  RUN_LAST = RUN_W'(NT_RUN - 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(IDLE_LIMIT);
  localparam logic [IDLE_W-1:0] IDLE_PRE = IDLE_W'(IDLE_LIMIT - 1);

  logic              rd_prev_q;
  logic [RUN_W-1:0]  run_q, run_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              frame_q, frame_d;
  logic              first_q, first_d;
  logic              nt_hit, line_start;

  assign rd_fall    = rd_prev_q & ~ppu_rd_n;
  assign nt_hit     = (ppu_addr[PPU_AW-1:PPU_AW-2] == NT_TAG);
  assign line_start = rd_fall & nt_hit & (run_q == RUN_LAST);
  assign idle_hit   = ~rd_fall & (idle_q == IDLE_PRE);

  always_comb begin
    // run of consecutive name-table fetches, saturating
    run_d = run_q;
    if (idle_hit) begin
      run_d = '0;
    end else if (rd_fall) begin
      if (!nt_hit) begin
        run_d = '0;
      end else if (run_q != RUN_MAX) begin
        run_d = run_q + RUN_W'(1);
      end
    end

    // fetch number within the scanline, saturating
    cnt_d = cnt_q;
    if (idle_hit) begin
      cnt_d = '0;
    end else if (line_start) begin
      cnt_d = CNT_W'(1);
    end else if (rd_fall && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CNT_W'(1);
    end

    // cycles since the last fetch, saturating
    if (rd_fall) begin
      idle_d = '0;
    end else if (idle_q != IDLE_MAX) begin
      idle_d = idle_q + IDLE_W'(1);
    end else begin
      idle_d = idle_q;
    end

    frame_d = frame_q;
    first_d = first_q;
    if (line_start) begin
      frame_d = 1'b1;
      first_d = ~frame_q;
    end else if (idle_hit) begin
      frame_d = 1'b0;
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev_q <= 1'b1;
      run_q     <= '0;
      cnt_q     <= '0;
      idle_q    <= '0;
      frame_q   <= 1'b0;
      first_q   <= 1'b0;
    end else begin
      rd_prev_q <= ppu_rd_n;
      run_q     <= run_d;
      cnt_q     <= cnt_d;
      idle_q    <= idle_d;
      frame_q   <= frame_d;
      first_q   <= first_d;
    end
  end

  assign fetch_cnt  = cnt_q;
  assign in_frame   = frame_q;
  assign first_line = first_q;

endmodule

// File: rtl/chrsel_window.sv
module chrsel_window
  import chrsel_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int WIN_LO = 130,
  parameter int WIN_HI = 161,
  parameter int LEAD_EN = 1,
  parameter int LEAD_LO = 2,
  parameter int LEAD_HI = 4
) (
  input  logic [CNT_W-1:0] fetch_cnt,
  input  logic             in_frame,
  input  logic             first_line,
  input  logic             tall_mode,
  input  bank_set_e        last_set,
  output bank_set_e        set_sel
);

  localparam logic [CNT_W-1:0] W_LO = CNT_W'(WIN_LO);
  localparam logic [CNT_W-1:0] W_HI = CNT_W'(WIN_HI);

  logic in_win, in_lead;

  assign in_win = (fetch_cnt >= W_LO) && (fetch_cnt <= W_HI);

  generate
    if (LEAD_EN != 0) begin : g_lead
      localparam logic [CNT_W-1:0] L_LO = CNT_W'(LEAD_LO);
      localparam logic [CNT_W-1:0] L_HI = CNT_W'(LEAD_HI);
      assign in_lead = first_line && (fetch_cnt >= L_LO) && (fetch_cnt <= L_HI);
    end else begin : g_no_lead
      assign in_lead = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!tall_mode) begin
      set_sel = SET_SPR;
    end else if (!in_frame) begin
      set_sel = last_set;
    end else if (in_win || in_lead) begin
      set_sel = SET_SPR;
    end else begin
      set_sel = SET_BG;
    end
  end

endmodule

// File: rtl/chr_set_selector.sv
module chr_set_selector
  import chrsel_pkg::*;
#(
  parameter int CPU_AW = 16,
  parameter int CPU_DW = 8,
  parameter int PPU_AW = 14,
  parameter int FETCH_MAX = 170,
  parameter int NT_RUN = 3,
  parameter int IDLE_LIMIT = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(FETCH_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [CPU_DW-1:0] cpu_data,
  input  logic              cpu_wr,
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic              ppu_rd_n,
  output logic              bg_set_sel
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  logic             tall_mode;
  bank_set_e        last_set;
  logic             rd_fall, idle_hit;
  logic [CNT_W-1:0] fetch_cnt;
  logic             in_frame, first_line;
  bank_set_e        set_sel;

  chrsel_cpu_snoop #(
    .CPU_AW(CPU_AW),
    .CPU_DW(CPU_DW)
  ) u_snoop (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .cpu_wr   (cpu_wr),
    .tall_mode(tall_mode),
    .last_set (last_set)
  );

  chrsel_line_track #(
    .PPU_AW    (PPU_AW),
    .FETCH_MAX (FETCH_MAX),
    .NT_RUN    (NT_RUN),
    .IDLE_LIMIT(IDLE_LIMIT)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ppu_addr  (ppu_addr),
    .ppu_rd_n  (ppu_rd_n),
    .rd_fall   (rd_fall),
    .idle_hit  (idle_hit),
    .fetch_cnt (fetch_cnt),
    .in_frame  (in_frame),
    .first_line(first_line)
  );

  chrsel_window #(
    .CNT_W(CNT_W)
  ) u_window (
    .fetch_cnt (fetch_cnt),
    .in_frame  (in_frame),
    .first_line(first_line),
    .tall_mode (tall_mode),
    .last_set  (last_set),
    .set_sel   (set_sel)
  );

  assign bg_set_sel = set_sel;

endmodule

// File: rtl/chrsel_checker.sv
module chrsel_checker #(
  parameter int FETCH_MAX = 170,
  parameter int IDLE_LIMIT = 32,
  localparam int CNT_W = $clog2(FETCH_MAX + 1),
  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_fall,
  input logic             idle_hit,
  input logic             tall_mode,
  input logic             in_frame,
  input logic             first_line,
  input logic             last_set,
  input logic [CNT_W-1:0] fetch_cnt,
  input logic             bg_set_sel
);

  logic [IDLE_W-1:0] quiet_cnt;

  // independent count of cycles without a fetch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt <= '0;
    end else if (rd_fall) begin
      quiet_cnt <= '0;
    end else if (quiet_cnt != IDLE_W'(IDLE_LIMIT)) begin
      quiet_cnt <= quiet_cnt + IDLE_W'(1);
    end
  end

  // R2
  small_sprite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tall_mode |-> (bg_set_sel == 1'b0));

  // R4
  fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tall_mode && !in_frame) |-> (bg_set_sel == last_set));

  // R6
  line_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> (fetch_cnt == CNT_W'(1)));

  // R8
  lead_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_line |-> in_frame);

  // R9
  count_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_cnt <= CNT_W'(FETCH_MAX));

  // R11
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_cnt == IDLE_W'(IDLE_LIMIT)) |-> !in_frame);

  // R12
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_fall && !idle_hit) |=> $stable(fetch_cnt));

endmodule

bind chr_set_selector chrsel_checker #(
  .FETCH_MAX (FETCH_MAX),
  .IDLE_LIMIT(IDLE_LIMIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .rd_fall   (rd_fall),
  .idle_hit  (idle_hit),
  .tall_mode (tall_mode),
  .in_frame  (in_frame),
  .first_line(first_line),
  .last_set  (last_set),
  .fetch_cnt (fetch_cnt),
  .bg_set_sel(bg_set_sel)
);

// File: tb/tb_chr_set_selector.sv
module tb_chr_set_selector;

  localparam int IDLE = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic        cpu_wr;
  logic [13:0] ppu_addr;
  logic        ppu_rd_n;
  logic        bg_set_sel;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  chr_set_selector dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_data  (cpu_data),
    .cpu_wr    (cpu_wr),
    .ppu_addr  (ppu_addr),
    .ppu_rd_n  (ppu_rd_n),
    .bg_set_sel(bg_set_sel)
  );

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // All tasks are entered and left at a falling clock edge.
  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic ppu_read(input logic [13:0] a, input int hold, output logic got);
    ppu_addr = a; ppu_rd_n = 1'b0;
    @(negedge clk);
    got = bg_set_sel;
    repeat (hold - 1) @(negedge clk);
    ppu_rd_n = 1'b1;
    @(negedge clk);
  endtask

  // fetch pattern: name, attribute, two pattern fetches; #169/#170 name
  function automatic logic [13:0] fetch_addr(input int f);
    if (f > 170) return 14'h0100;
    if (f >= 169) return 14'h2000;
    case ((f - 1) % 4)
      0: return 14'h2000 | 14'(f & 255);
      1: return 14'h23C0;
      default: return 14'h0000 | 14'(f & 255);
    endcase
  endfunction

  function automatic logic exp_sel(input int line, input int f, input logic tall,
                                   input logic framed, input logic last);
    int n;
    n = (f > 170) ? 170 : f;
    if (!tall) return 1'b0;
    if (!framed) return last;
    if (n >= 130 && n <= 161) return 1'b0;
    if (line == 0 && n >= 2 && n <= 4) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run_line(input int line, input int nfetch, input logic tall,
                          input logic last, input int hold_at);
    logic got;
    string tag;
    for (int f = 1; f <= nfetch; f++) begin
      ppu_read(fetch_addr(f), (f == hold_at) ? 4 : 1, got);
      if (!tall) tag = "R2";
      else if (line < 0) tag = "R6";
      else if (hold_at > 0 && f > hold_at && f <= hold_at + 2) tag = "R12";
      else if (f > 170) tag = "R9";
      else if (line >= 260) tag = "R10";
      else if (line == 0 && f <= 4) tag = "R8";
      else tag = "R7";
      check(got, exp_sel(line, f, tall, line >= 0, last), tag,
            $sformatf("line %0d fetch %0d", line, f));
    end
  endtask

  task automatic run_frame(input int nlines, input logic tall, input logic last,
                           input int hold_line, input int hold_at, input logic extend);
    run_line(-1, 170, tall, last, 0);
    for (int l = 0; l < nlines; l++) begin
      run_line(l, (extend && l == nlines - 1) ? 340 : 170, tall, last,
               (l == hold_line) ? hold_at : 0);
    end
    repeat (IDLE - 2) @(negedge clk);
    check(bg_set_sel, tall, "R11", "one cycle before idle timeout");
    @(negedge clk);
    check(bg_set_sel, tall ? last : 1'b0, "R11", "at idle timeout");
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic got;
    rst_n = 1'b0; cpu_addr = '0; cpu_data = '0; cpu_wr = 1'b0;
    ppu_addr = '0; ppu_rd_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state and tall-sprite default
    check(bg_set_sel, 1'b0, "R1", "after reset");
    cpu_write(16'h5129, 8'h00);
    check(bg_set_sel, 1'b1, "R1", "set B write with default mode");

    // R5 clearing bit 5 forces set A and blocks set-B writes
    cpu_write(16'h2000, 8'h00);
    check(bg_set_sel, 1'b0, "R5", "bit 5 cleared");
    cpu_write(16'h5128, 8'h00);
    cpu_write(16'h2000, 8'h20);
    check(bg_set_sel, 1'b0, "R5", "set B write ignored while small");
    cpu_write(16'h512A, 8'h00);
    check(bg_set_sel, 1'b1, "R5", "set B write accepted when tall");

    // R2 every control byte against every show-bit pair
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 256; c++) begin
        logic [7:0] mb;
        logic [7:0] cb;
        cb = 8'(c);
        mb = 8'(((m & 1) << 3) | ((m >> 1) << 4) | (c & 8'hE7));
        cpu_write(16'h2000, 8'h20);
        cpu_write(16'h2001, 8'h18);
        cpu_write(16'h5128, 8'h00);
        cpu_write(16'h2001, mb);
        cpu_write(16'h2000, cb);
        check(bg_set_sel, cb[5] & (mb[3] | mb[4]), "R2",
              $sformatf("ctrl %02h mask %02h", cb, mb));
      end
    end

    // R3 mirrors of both configuration registers are ignored
    cpu_write(16'h2000, 8'h20);
    cpu_write(16'h2001, 8'h18);
    cpu_write(16'h5128, 8'h00);
    for (int k = 1; k < 1024; k++) begin
      cpu_write(16'h2000 + 16'(8 * k), 8'h00);
      check(bg_set_sel, 1'b1, "R3", $sformatf("mirror %04h", 16'h2000 + 16'(8 * k)));
      cpu_write(16'h2001 + 16'(8 * k), 8'h00);
      check(bg_set_sel, 1'b1, "R3", $sformatf("mirror %04h", 16'h2001 + 16'(8 * k)));
    end

    // R4 bank register neighbourhood
    for (int a = 16'h5110; a < 16'h5140; a++) begin
      cpu_write(16'h5128, 8'h00);
      cpu_write(16'(a), 8'h00);
      check(bg_set_sel, (a >= 16'h5120 && a <= 16'h5127) ? 1'b0 : 1'b1, "R4",
            $sformatf("write %04h after set B", a));
      cpu_write(16'h5120, 8'h00);
      cpu_write(16'(a), 8'h00);
      check(bg_set_sel, (a >= 16'h5128 && a <= 16'h512B) ? 1'b1 : 1'b0, "R4",
            $sformatf("write %04h after set A", a));
    end

    // R6 two name-table fetches do not start a line, three do
    cpu_write(16'h5120, 8'h00);
    for (int r = 0; r < 3; r++) begin
      ppu_read(14'h2001, 1, got);
      check(got, 1'b0, "R6", "first name fetch");
      ppu_read(14'h2002, 1, got);
      check(got, 1'b0, "R6", "second name fetch");
      ppu_read(14'h0010, 1, got);
      check(got, 1'b0, "R6", "pattern fetch breaks run");
    end
    ppu_read(14'h2001, 1, got);
    ppu_read(14'h2002, 1, got);
    check(got, 1'b0, "R6", "two in a row");
    ppu_read(14'h2003, 1, got);
    check(got, 1'b1, "R6", "third in a row enters frame at fetch 1");
    repeat (IDLE + 2) @(negedge clk);
    check(bg_set_sel, 1'b0, "R11", "frame left after idle");

    // frames: set A last, with held strobe and an over-long last line
    run_frame(3, 1'b1, 1'b0, 1, 128, 1'b1);

    // tall frame, set B last, 300 lines
    cpu_write(16'h512B, 8'h00);
    run_frame(300, 1'b1, 1'b1, -1, 0, 1'b0);

    // small-sprite frame
    cpu_write(16'h2001, 8'h00);
    run_frame(2, 1'b0, 1'b1, -1, 0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule